// File: doc/BRIEF.md
# Destructive-Read Core Memory Cycle Controller

This block runs a single access to a coincident-current magnetic core array that is 18 planes deep: 16 data bits and 2 parity bits, one plane per bit. Reading a core array is destructive. The read pulse forces every selected core to zero, and a plane reports a sense signal only if its core held a one beforehand. For this reason every access is built from the same two phases. A read phase senses the word and clears it. A write phase then drives the selected cores toward one, and each plane whose bit must stay zero has its inhibit asserted.

On a read request the sensed word is written back unchanged and is returned on the read data port. On a write request the sensed word is thrown away and the request data is written in its place. Each plane's sense wire and inhibit wire are the same conductor. Each plane is split into four sense segments, and the controller ORs the four segment outputs of a bit into one value. The length of each drive pulse is set per access in clock cycles. The surrounding memory unit issues requests, and only one access can be in flight at a time.

Top module: `core_cycle_ctrl`

## Requirements
- R1: While reset is asserted, and in the idle cycle that follows its release, `busy`, `done`, `drv_read`, `drv_write`, `sense_stb`, `inhibit` and `rdata` are all zero.
- R2: A request is taken only at a clock edge where `req_valid` is high and `busy` is low. `busy` goes high in the cycle after that edge and stays high up to and including the `done` cycle. A request made while `busy` is high is ignored and does not change the array.
- R3: `drv_read` is high for exactly L cycles, starting in the first cycle after acceptance. L is taken from `pulse_cycles` at acceptance. After the read, the array word at `arr_addr` again holds its previous value.
- R4: `sense_stb` is high for one cycle, at read-phase cycle STB_OFS (counted from 0; default 8). At that edge, bit b of the sensed word is the OR of `sense_seg[b*SEGS + s]` over all segments s.
- R5: `inhibit` is all zeros in every cycle outside the write phase, which includes the whole read phase and the sense strobe.
- R6: Between the end of `drv_read` and the start of `drv_write` there are exactly GAP_CYC cycles (default 2) with both drive outputs low. The two drive outputs are never high together.
- R7: `drv_write` is high for exactly L cycles. During those cycles `inhibit[b]` is the inverse of bit b of the word being stored. That word is the sensed word for a read and `req_wdata` captured at acceptance for a write.
- R8: `done` is high for one cycle, immediately after the write phase. For a read, `rdata` equals the sensed word in that cycle. A write leaves `rdata` unchanged.
- R9: L is `pulse_cycles` clamped to the range MIN_LEN..MAX_LEN (default 40..70). A request value of 5 gives 40 cycles and a value of 127 gives 70.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | AW | Word address |
| req_wdata | input | W | Word to store on a write |
| pulse_cycles | input | CNT_W | Requested drive pulse length in cycles |
| sense_seg | input | W*SEGS | Segment sense outputs, bit b segment s at index b*SEGS+s |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion strobe |
| rdata | output | W | Word sensed by the last read |
| arr_addr | output | AW | Address held for the array drivers |
| drv_read | output | 1 | Read drive phase |
| drv_write | output | 1 | Write drive phase |
| sense_stb | output | 1 | Sense sampling strobe |
| inhibit | output | W | Per-plane inhibit during the write phase |

## Verification
The assertions assume that `req_valid` and its fields are known values after reset. They also assume that `sense_seg` carries a meaningful signal only while `drv_read` is high. They make no assumption about `pulse_cycles`, because the pulse-length window they check is guaranteed by the clamp itself. The stimulus changes inputs only at falling edges. It includes pulse requests below, inside and above the legal range. It keeps addresses within the array model's 64 words, and its sense model drives only the segment chosen by the address, only during the read drive.

// File: rtl/ccc_pkg.sv
package ccc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_READ  = 3'd1,
    PH_GAP   = 3'd2,
    PH_WRITE = 3'd3,
    PH_DONE  = 3'd4
  } phase_t;

  // Limit a requested drive length to the legal window.
  function automatic int clamp_len(input int req, input int lo, input int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/ccc_seq.sv
module ccc_seq #(
  parameter int CNT_W   = 7,
  parameter int MIN_LEN = 40,
  parameter int MAX_LEN = 70,
  parameter int GAP_CYC = 2,
  parameter int STB_OFS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CNT_W-1:0]   len_req,
  output ccc_pkg::phase_t    phase,
  output logic               sense_stb
);
  import ccc_pkg::*;

  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] STB_AT   = CNT_W'(STB_OFS);
  localparam logic [CNT_W-1:0] LEN_RST  = CNT_W'(MIN_LEN);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_q;
  logic             cnt_last;

  always_comb begin
    if (phase == PH_GAP) cnt_last = (cnt == GAP_LAST);
    else                 cnt_last = (cnt == len_q - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      len_q <= LEN_RST;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_READ;
          cnt   <= '0;
          len_q <= CNT_W'(clamp_len(int'(len_req), MIN_LEN, MAX_LEN));
        end
        PH_READ: begin
          if (cnt_last) begin phase <= PH_GAP; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        PH_GAP: begin
          if (cnt_last) begin phase <= PH_WRITE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        PH_WRITE: begin
          if (cnt_last) begin phase <= PH_DONE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign sense_stb = (phase == PH_READ) && (cnt == STB_AT);

endmodule

// File: rtl/ccc_sense.sv
module ccc_sense #(
  parameter int W    = 18,
  parameter int SEGS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic [W*SEGS-1:0] seg_in,
  output logic [W-1:0]    word_q
);
  logic [W-1:0] bit_hit;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign bit_hit[b] = |seg_in[b*SEGS +: SEGS];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      word_q <= '0;
    else if (strobe) word_q <= bit_hit;
  end

endmodule

// File: rtl/ccc_data.sv
module ccc_data #(
  parameter int W  = 18,
  parameter int AW = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [W-1:0]    req_wdata,
  input  logic [W-1:0]    sensed,
  input  ccc_pkg::phase_t phase,
  output logic [AW-1:0]   arr_addr,
  output logic [W-1:0]    inhibit,
  output logic [W-1:0]    rdata
);
  import ccc_pkg::*;

  logic          wr_q;
  logic [W-1:0]  wdata_q;
  logic [W-1:0]  store_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      wdata_q  <= '0;
      arr_addr <= '0;
      rdata    <= '0;
    end else begin
      if (capture) begin
        wr_q     <= req_write;
        wdata_q  <= req_wdata;
        arr_addr <= req_addr;
      end
      // Sensed word is stable once the strobe has passed; publish it in the gap.
      if (phase == PH_GAP && !wr_q) rdata <= sensed;
    end
  end

  assign store_word = wr_q ? wdata_q : sensed;
  assign inhibit    = (phase == PH_WRITE) ? ~store_word : '0;

endmodule

// File: rtl/core_cycle_ctrl.sv
module core_cycle_ctrl #(
  parameter int W       = 18,
  parameter int SEGS    = 4,
  parameter int AW      = 15,
  parameter int CNT_W   = 7,
  parameter int MIN_LEN = 40,
  parameter int MAX_LEN = 70,
  parameter int GAP_CYC = 2,
  parameter int STB_OFS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [W-1:0]      req_wdata,
  input  logic [CNT_W-1:0]  pulse_cycles,
  input  logic [W*SEGS-1:0] sense_seg,
  output logic              busy,
  output logic              done,
  output logic [W-1:0]      rdata,
  output logic [AW-1:0]     arr_addr,
  output logic              drv_read,
  output logic              drv_write,
  output logic              sense_stb,
  output logic [W-1:0]      inhibit
);
  import ccc_pkg::*;

  phase_t       phase;
  logic         accept;
  logic [W-1:0] sensed_word;

  assign accept = req_valid && (phase == PH_IDLE);

  ccc_seq #(
    .CNT_W(CNT_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN),
    .GAP_CYC(GAP_CYC), .STB_OFS(STB_OFS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .len_req(pulse_cycles),
    .phase(phase), .sense_stb(sense_stb)
  );

  ccc_sense #(.W(W), .SEGS(SEGS)) u_sense (
    .clk(clk), .rst_n(rst_n), .strobe(sense_stb), .seg_in(sense_seg),
    .word_q(sensed_word)
  );

  ccc_data #(.W(W), .AW(AW)) u_data (
    .clk(clk), .rst_n(rst_n), .capture(accept), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .sensed(sensed_word),
    .phase(phase), .arr_addr(arr_addr), .inhibit(inhibit), .rdata(rdata)
  );

  assign busy      = (phase != PH_IDLE);
  assign done      = (phase == PH_DONE);
  assign drv_read  = (phase == PH_READ);
  assign drv_write = (phase == PH_WRITE);

endmodule

// File: rtl/ccc_checker.sv
module ccc_checker #(
  parameter int W       = 18,
  parameter int MIN_LEN = 40,
  parameter int MAX_LEN = 70
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         busy,
  input logic         done,
  input logic         drv_read,
  input logic         drv_write,
  input logic         sense_stb,
  input logic [W-1:0] inhibit
);
  int rd_run;
  int wr_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_run <= 0;
      wr_run <= 0;
    end else begin
      rd_run <= drv_read  ? rd_run + 1 : 0;
      wr_run <= drv_write ? wr_run + 1 : 0;
    end
  end

  a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  a_r3_read_len_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_read) |-> (rd_run >= MIN_LEN && rd_run <= MAX_LEN));

  a_r4_strobe_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    sense_stb |-> drv_read);

  a_r5_no_inhibit_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    drv_read |-> (inhibit == '0));

  a_r5_inhibit_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|inhibit) |-> drv_write);

  a_r6_gap_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_read) |-> !drv_write ##1 !drv_write);

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_read && drv_write));

  a_r7_write_len_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_write) |-> (wr_run >= MIN_LEN && wr_run <= MAX_LEN));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

endmodule

bind core_cycle_ctrl ccc_checker #(.W(W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .drv_read(drv_read), .drv_write(drv_write), .sense_stb(sense_stb), .inhibit(inhibit)
);

// File: tb/tb_core_cycle_ctrl.sv
module tb_core_cycle_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 18, SEGS = 4, AW = 6, CNT_W = 7;
  localparam int MINL = 40, MAXL = 70, GAP = 2, OFS = 8;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [W-1:0] req_wdata;
  logic [CNT_W-1:0] pulse_cycles;
  logic [W*SEGS-1:0] sense_seg;
  logic busy, done, drv_read, drv_write, sense_stb;
  logic [W-1:0] rdata, inhibit;
  logic [AW-1:0] arr_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_cycle_ctrl #(.W(W), .SEGS(SEGS), .AW(AW), .CNT_W(CNT_W), .MIN_LEN(MINL),
    .MAX_LEN(MAXL), .GAP_CYC(GAP), .STB_OFS(OFS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .pulse_cycles(pulse_cycles),
    .sense_seg(sense_seg), .busy(busy), .done(done), .rdata(rdata),
    .arr_addr(arr_addr), .drv_read(drv_read), .drv_write(drv_write),
    .sense_stb(sense_stb), .inhibit(inhibit));

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int bench_len(input int v);
    return (v < MINL) ? MINL : ((v > MAXL) ? MAXL : v);
  endfunction

  // ---------------- core array model ----------------
  logic [W-1:0] amem [WORDS];
  logic [W-1:0] snap = '0;
  logic snap_v = 1'b0, prev_rd = 1'b0;

  always @(posedge clk) begin
    prev_rd <= drv_read;
    if (drv_read && !prev_rd) begin
      snap <= amem[arr_addr];
      amem[arr_addr] <= '0;     // destructive read
      snap_v <= 1'b1;
    end else if (!drv_read) snap_v <= 1'b0;
    if (drv_write) amem[arr_addr] <= amem[arr_addr] | ~inhibit;
  end

  always @* begin
    sense_seg = '0;
    if (drv_read && snap_v)
      for (int b = 0; b < W; b++) sense_seg[b*SEGS + (int'(arr_addr) % SEGS)] = snap[b];
  end

  // ---------------- reference model ----------------
  int k = -1, L = MINL, r_addr = 0;
  bit r_wr = 1'b0;
  logic [W-1:0] r_wdata = '0, r_old = '0, last_rd = '0;
  logic [W-1:0] shadow [WORDS];

  always @(posedge clk) begin
    if (!rst_n) k = -1;
    else if (k < 0) begin
      if (req_valid) begin
        k = 0; L = bench_len(int'(pulse_cycles)); r_wr = req_write;
        r_addr = int'(req_addr); r_wdata = req_wdata; r_old = shadow[r_addr];
      end
    end else if (k == 2*L + GAP) begin
      if (r_wr) shadow[r_addr] = r_wdata; else last_rd = r_old;
      k = -1;
    end else k++;
  end

  always @(negedge clk) if (rst_n) begin
    bit e_busy, e_rd, e_wr, e_stb, e_done, e_gap;
    logic [W-1:0] e_inh;
    e_busy = (k >= 0);
    e_rd   = (k >= 0) && (k < L);
    e_gap  = (k >= L) && (k < L + GAP);
    e_wr   = (k >= L + GAP) && (k < 2*L + GAP);
    e_stb  = (k == OFS);
    e_done = (k == 2*L + GAP);
    e_inh  = e_wr ? ~(r_wr ? r_wdata : r_old) : '0;
    check(busy == e_busy, "R2 busy", busy, e_busy);
    check(drv_read == e_rd, "R3 R9 drv_read", drv_read, e_rd);
    check(sense_stb == e_stb, "R4 sense_stb", sense_stb, e_stb);
    check(drv_write == e_wr, "R7 drv_write", drv_write, e_wr);
    check(inhibit == e_inh, e_wr ? "R7 inhibit" : "R5 inhibit", inhibit, e_inh);
    check(done == e_done, "R8 done", done, e_done);
    if (e_gap) check(!drv_read && !drv_write, "R6 gap drive", {drv_read, drv_write}, 0);
    if (e_done) check(rdata == (r_wr ? last_rd : r_old), "R8 rdata at done", rdata, r_wr ? last_rd : r_old);
    if (k < 0) check(rdata == last_rd, "R8 rdata hold", rdata, last_rd);
  end

  // ---------------- stimulus ----------------
  task automatic access(input bit w, input int a, input logic [W-1:0] d, input int len);
    int rc = 0, wc = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_wdata = d; pulse_cycles = CNT_W'(len);
    @(negedge clk);
    req_valid = 1'b0; pulse_cycles = '0; req_wdata = ~d;
    while (!done) begin
      if (drv_read) rc++;
      if (drv_write) wc++;
      @(negedge clk);
    end
    check(rc == bench_len(len), "R9 read pulse length", rc, bench_len(len));
    check(wc == bench_len(len), "R7 write pulse length", wc, bench_len(len));
    @(negedge clk);
    check(amem[a] == shadow[a], "R3 R7 array word after access", amem[a], shadow[a]);
  endtask

  function automatic logic [W-1:0] pat(input int i);
    return W'(32'h9E37 * (i + 1) ^ (i << 11));
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int dn;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; pulse_cycles = 7'd50;
    for (int i = 0; i < WORDS; i++) begin amem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, done, drv_read, drv_write, sense_stb} == 5'b0, "R1 controls in reset",
          {busy, done, drv_read, drv_write, sense_stb}, 0);
    check(inhibit == '0, "R1 inhibit in reset", inhibit, 0);
    check(rdata == '0, "R1 rdata in reset", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !drv_read && !drv_write, "R1 idle after reset", busy, 0);

    // writes with several patterns and lengths
    access(1, 0, 18'h3FFFF, 40);
    access(1, 1, 18'h00000, 70);
    access(1, 2, 18'h2AAAA, 55);
    access(1, 3, 18'h15555, 41);
    access(1, 4, 18'h20001, 69);
    for (int i = 5; i < 13; i++) access(1, i, pat(i), 45 + i);

    // reads: destructive sense, restore, segment OR (R4)
    for (int i = 0; i < 13; i++) access(0, i, 18'h0, 50);
    access(0, 2, 18'h0, 50);   // second read proves restore (R3)
    access(0, 3, 18'h0, 50);

    // clamp of the pulse length (R9)
    access(0, 2, 18'h0, 5);
    access(0, 3, 18'h0, 127);
    access(1, 6, 18'h0F0F0, 0);
    access(0, 6, 18'h0, 70);

    // request while busy is ignored (R2)
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = AW'(4); pulse_cycles = 7'd50;
    @(negedge clk);
    req_valid = 0;
    repeat (20) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = AW'(9); req_wdata = 18'h0;
    repeat (3) @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    access(0, 9, 18'h0, 50);
    check(amem[9] == pat(9), "R2 ignored request left word", amem[9], pat(9));

    // back-to-back accepts with request held high
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = AW'(5); pulse_cycles = 7'd42;
    dn = 0;
    while (dn < 2) begin @(negedge clk); if (done) dn++; end
    req_valid = 0;
    repeat (3) @(negedge clk);
    check(amem[5] == pat(5), "R3 word after back-to-back reads", amem[5], pat(5));

    finish_run();
  end

endmodule